// File: doc/BRIEF.md
# Coprocessor Condition Branch Sequencer

This block walks a main processor through instructions whose outcome depends on a condition that an external coprocessor evaluates. It fetches an operation word at the program counter and checks the line prefix. It decodes the coprocessor number and the instruction kind, then writes a condition word to the coprocessor's condition register. It polls the coprocessor's response register until the coprocessor reports a resolved condition. Polls that come back unresolved are service requests. On each of them the block polls again.

For the set-on-condition kind, the resolved truth value becomes a flag byte, all ones for true and all zeros for false. The byte is presented on a flag-write strobe together with the operation word's effective-address mode field. For the branch kinds, a false outcome falls through to the next sequential instruction. A true outcome fetches a 16-bit or 32-bit two's-complement displacement. The block sign-extends the displacement and adds it to a scan pointer that addresses the displacement's first word. A parameter sets how many coprocessor-defined extension words the scan pointer skips.

Top module: `cp_cond_seq`

## Requirements
- R1: After reset, pc_o equals RESET_PC and fetch_req_o is high with fetch_addr_o equal to pc_o. done_o, illegal_o, flag_we_o and cp_we_o are all low.
- R2: An operation word whose bits 15:12 are not 1111 pulses illegal_o and done_o together for one cycle. It makes no coprocessor access, and pc_o becomes the word's address plus 2.
- R3: An operation word with prefix 1111 is decoded by bits 8:6: 001 is set-on-condition, 010 is a branch with a 16-bit displacement, and 011 is a branch with a 32-bit displacement. Any other value is treated as in R2. cp_id_o carries operation-word bits 11:9 during every coprocessor access.
- R4: For set-on-condition, the condition word is fetched at address A+2, where A is the operation-word address. If its bits 15:10 and 9:6 are not all zero, illegal_o pulses with done_o and pc_o becomes A+4+2*EXT_WORDS. No coprocessor write and no flag write follow.
- R5: Each accepted instruction causes exactly one coprocessor write, with cp_reg_o low, and that write comes before any response read. The written data is the condition word for set-on-condition. For a branch it is operation-word bits 5:0, zero-extended.
- R6: A response read drives cp_re_o high with cp_reg_o high. If response bit 15 is 0, the read is a service request and the block reads again in the next cycle. If bit 15 is 1, the condition is resolved and bit 0 gives its truth value.
- R7: A resolved set-on-condition pulses flag_we_o once, together with done_o. flag_data_o is 8'hFF for true and 8'h00 for false, flag_ea_o equals operation-word bits 5:0, and pc_o becomes A+4+2*EXT_WORDS.
- R8: A false branch sets pc_o to S+2 for a 16-bit displacement or S+4 for a 32-bit one, where S = A+2+2*EXT_WORDS. No displacement word is fetched.
- R9: A true 16-bit branch fetches the displacement at S and sets pc_o to S plus the sign-extended displacement.
- R10: A true 32-bit branch fetches the upper half at S and the lower half at S+2, and sets pc_o to S plus the 32-bit displacement.
- R11: While fetch_req_o is high and fetch_valid_i is low, fetch_req_o stays high and fetch_addr_o holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_o | output | 1 | Instruction word fetch request |
| fetch_addr_o | output | ADDR_W | Byte address of the requested word |
| fetch_valid_i | input | 1 | Fetch data valid this cycle |
| fetch_data_i | input | 16 | Fetched instruction word |
| cp_we_o | output | 1 | Coprocessor register write strobe |
| cp_re_o | output | 1 | Coprocessor register read strobe |
| cp_reg_o | output | 1 | Register select: 0 condition, 1 response |
| cp_id_o | output | 3 | Target coprocessor number |
| cp_wdata_o | output | 16 | Condition word written to the coprocessor |
| cp_rdata_i | input | 16 | Response word, sampled while cp_re_o is high |
| pc_o | output | ADDR_W | Address of the next instruction |
| done_o | output | 1 | One-cycle pulse when pc_o takes a new value |
| flag_we_o | output | 1 | Flag byte write strobe |
| flag_data_o | output | 8 | Flag byte value |
| flag_ea_o | output | 6 | Effective-address mode field for the flag write |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The hardest situation to reach is a fetch stall and a service-request chain landing inside the same instruction, so that address holding and repeated polling are both exercised while the scan pointer sits past the extension words. The stimulus withholds fetch_valid_i at random on a third of request cycles. It gives each instruction a random number of unresolved responses before the resolved one. Directed cases pin long service-request runs, negative displacements and reserved-bit violations, and a few hundred random instructions mix all kinds.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;
  localparam int WORD_W     = 16;
  localparam int SEL_W      = 6;
  localparam int ID_W       = 3;
  localparam logic [3:0] LINE_PREFIX = 4'hF;
  localparam logic [2:0] TYP_SET   = 3'b001;
  localparam logic [2:0] TYP_BR_S  = 3'b010;
  localparam logic [2:0] TYP_BR_L  = 3'b011;
  localparam int RESP_DONE_BIT  = 15;
  localparam int RESP_TRUTH_BIT = 0;
  localparam logic REG_COND = 1'b0;
  localparam logic REG_RESP = 1'b1;

  typedef enum logic [1:0] {K_BAD, K_SET, K_BR_S, K_BR_L} kind_e;

  typedef enum logic [2:0] {
    ST_OP, ST_CW, ST_WR, ST_POLL, ST_D0, ST_D1
  } state_e;

  typedef struct packed {
    logic resolved;
    logic truth;
  } resp_t;
endpackage

// File: rtl/cp_op_decode.sv
module cp_op_decode
  import cp_seq_pkg::*;
(
  input  logic [WORD_W-1:0] op_i,
  output kind_e             kind_o,
  output logic [ID_W-1:0]   id_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic       line_ok;
  logic [2:0] typ;

  assign line_ok = (op_i[15:12] == LINE_PREFIX);
  assign typ     = op_i[8:6];
  assign id_o    = op_i[11:9];
  assign sel_o   = op_i[SEL_W-1:0];

  always_comb begin
    kind_o = K_BAD;
    if (line_ok) begin
      unique case (typ)
        TYP_SET:  kind_o = K_SET;
        TYP_BR_S: kind_o = K_BR_S;
        TYP_BR_L: kind_o = K_BR_L;
        default:  kind_o = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/cp_resp_decode.sv
module cp_resp_decode
  import cp_seq_pkg::*;
(
  input  logic [WORD_W-1:0] resp_i,
  output resp_t             resp_o
);
  assign resp_o.resolved = resp_i[RESP_DONE_BIT];
  assign resp_o.truth    = resp_i[RESP_TRUTH_BIT];
endmodule

// File: rtl/cp_target_add.sv
module cp_target_add #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              long_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int HALF_W = DISP_W / 2;

  logic signed [ADDR_W-1:0] disp_ext;

  always_comb begin
    if (long_i) disp_ext = ADDR_W'($signed(disp_i));
    else        disp_ext = ADDR_W'($signed(disp_i[HALF_W-1:0]));
  end

  assign sum_o = base_i + disp_ext;
endmodule

// File: rtl/cp_cond_seq.sv
module cp_cond_seq
  import cp_seq_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              EXT_WORDS = 1,
  parameter logic [ADDR_W-1:0] RESET_PC = 'h1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                fetch_req_o,
  output logic [ADDR_W-1:0]   fetch_addr_o,
  input  logic                fetch_valid_i,
  input  logic [WORD_W-1:0]   fetch_data_i,
  output logic                cp_we_o,
  output logic                cp_re_o,
  output logic                cp_reg_o,
  output logic [ID_W-1:0]     cp_id_o,
  output logic [WORD_W-1:0]   cp_wdata_o,
  input  logic [WORD_W-1:0]   cp_rdata_i,
  output logic [ADDR_W-1:0]   pc_o,
  output logic                done_o,
  output logic                flag_we_o,
  output logic [7:0]          flag_data_o,
  output logic [SEL_W-1:0]    flag_ea_o,
  output logic                illegal_o
);
  localparam logic [ADDR_W-1:0] STEP_W   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_L   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] EXT_SKIP = ADDR_W'(2 * EXT_WORDS);
  localparam int                DISP_W   = 2 * WORD_W;

  state_e              state_q;
  kind_e               kind_q;
  logic [ADDR_W-1:0]   pc_q, scan_q;
  logic [WORD_W-1:0]   cw_q, hi_q;
  logic [ID_W-1:0]     id_q;
  logic [SEL_W-1:0]    ea_q;
  logic                done_q, ill_q, flag_we_q;
  logic [7:0]          flag_q;

  kind_e               dec_kind;
  logic [ID_W-1:0]     dec_id;
  logic [SEL_W-1:0]    dec_sel;
  resp_t               resp;
  logic [DISP_W-1:0]   disp_word;
  logic [ADDR_W-1:0]   target;
  logic                take;

  cp_op_decode u_dec (
    .op_i   (fetch_data_i),
    .kind_o (dec_kind),
    .id_o   (dec_id),
    .sel_o  (dec_sel)
  );

  cp_resp_decode u_resp (
    .resp_i (cp_rdata_i),
    .resp_o (resp)
  );

  assign disp_word = (state_q == ST_D1) ? {hi_q, fetch_data_i}
                                        : {{WORD_W{1'b0}}, fetch_data_i};

  cp_target_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_add (
    .base_i (scan_q),
    .disp_i (disp_word),
    .long_i (state_q == ST_D1),
    .sum_o  (target)
  );

  always_comb begin
    fetch_req_o  = 1'b0;
    fetch_addr_o = pc_q;
    unique case (state_q)
      ST_OP: begin fetch_req_o = 1'b1; fetch_addr_o = pc_q;          end
      ST_CW,
      ST_D0: begin fetch_req_o = 1'b1; fetch_addr_o = scan_q;        end
      ST_D1: begin fetch_req_o = 1'b1; fetch_addr_o = scan_q + STEP_W; end
      default: ;
    endcase
  end

  assign take        = fetch_req_o & fetch_valid_i;
  assign cp_we_o     = (state_q == ST_WR);
  assign cp_re_o     = (state_q == ST_POLL);
  assign cp_reg_o    = cp_re_o ? REG_RESP : REG_COND;
  assign cp_wdata_o  = cw_q;
  assign cp_id_o     = id_q;
  assign pc_o        = pc_q;
  assign done_o      = done_q;
  assign illegal_o   = ill_q;
  assign flag_we_o   = flag_we_q;
  assign flag_data_o = flag_q;
  assign flag_ea_o   = ea_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OP;
      kind_q    <= K_BAD;
      pc_q      <= RESET_PC;
      scan_q    <= RESET_PC;
      cw_q      <= '0;
      hi_q      <= '0;
      id_q      <= '0;
      ea_q      <= '0;
      done_q    <= 1'b0;
      ill_q     <= 1'b0;
      flag_we_q <= 1'b0;
      flag_q    <= 8'h00;
    end else begin
      done_q    <= 1'b0;
      ill_q     <= 1'b0;
      flag_we_q <= 1'b0;
      unique case (state_q)
        ST_OP: if (take) begin
          kind_q <= dec_kind;
          id_q   <= dec_id;
          ea_q   <= dec_sel;
          unique case (dec_kind)
            K_BAD: begin
              ill_q  <= 1'b1;
              done_q <= 1'b1;
              pc_q   <= pc_q + STEP_W;
            end
            K_SET: begin
              scan_q  <= pc_q + STEP_W;
              state_q <= ST_CW;
            end
            default: begin
              scan_q  <= pc_q + STEP_W + EXT_SKIP;
              cw_q    <= {{(WORD_W-SEL_W){1'b0}}, dec_sel};
              state_q <= ST_WR;
            end
          endcase
        end
        ST_CW: if (take) begin
          if (|fetch_data_i[WORD_W-1:SEL_W]) begin
            ill_q   <= 1'b1;
            done_q  <= 1'b1;
            pc_q    <= scan_q + STEP_W + EXT_SKIP;
            state_q <= ST_OP;
          end else begin
            cw_q    <= fetch_data_i;
            scan_q  <= scan_q + STEP_W + EXT_SKIP;
            state_q <= ST_WR;
          end
        end
        ST_WR: state_q <= ST_POLL;
        ST_POLL: if (resp.resolved) begin
          if (kind_q == K_SET) begin
            flag_we_q <= 1'b1;
            flag_q    <= resp.truth ? 8'hFF : 8'h00;
            pc_q      <= scan_q;
            done_q    <= 1'b1;
            state_q   <= ST_OP;
          end else if (!resp.truth) begin
            pc_q    <= scan_q + ((kind_q == K_BR_L) ? STEP_L : STEP_W);
            done_q  <= 1'b1;
            state_q <= ST_OP;
          end else begin
            state_q <= ST_D0;
          end
        end
        ST_D0: if (take) begin
          if (kind_q == K_BR_L) begin
            hi_q    <= fetch_data_i;
            state_q <= ST_D1;
          end else begin
            pc_q    <= target;
            done_q  <= 1'b1;
            state_q <= ST_OP;
          end
        end
        ST_D1: if (take) begin
          pc_q    <= target;
          done_q  <= 1'b1;
          state_q <= ST_OP;
        end
        default: state_q <= ST_OP;
      endcase
    end
  end

  p_addr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_valid_i |=> fetch_req_o && $stable(fetch_addr_o));

  p_write_before_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cp_re_o) |-> $past(cp_we_o));

  p_one_port_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cp_we_o, cp_re_o, fetch_req_o}));

  p_retry_poll_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_re_o && !cp_rdata_i[RESP_DONE_BIT] |=> cp_re_o && $stable(cp_id_o));

  p_flag_value_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> done_o && (flag_data_o == 8'hFF || flag_data_o == 8'h00));

  p_illegal_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o && !flag_we_o);

  p_cond_reserved_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_we_o |-> (cp_wdata_o[WORD_W-1:SEL_W] == '0) && (cp_reg_o == REG_COND));
endmodule

// File: tb/cp_cond_seq_bench.sv
module cp_cond_seq_bench;
  localparam int          EXT    = 2;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_req_o, fetch_valid_i;
  logic [31:0] fetch_addr_o, pc_o;
  logic [15:0] fetch_data_i, cp_wdata_o, cp_rdata_i;
  logic        cp_we_o, cp_re_o, cp_reg_o, done_o, flag_we_o, illegal_o;
  logic [2:0]  cp_id_o;
  logic [7:0]  flag_data_o;
  logic [5:0]  flag_ea_o;

  int checks = 0;
  int errors = 0;
  bit hung = 0;
  logic [15:0] words [8];
  logic [31:0] base;

  always #5 clk_i = ~clk_i;

  cp_cond_seq #(.ADDR_W(32), .EXT_WORDS(EXT), .RESET_PC(RST_PC)) u_cp_cond_seq (
    .clk_i, .rst_ni, .fetch_req_o, .fetch_addr_o, .fetch_valid_i, .fetch_data_i,
    .cp_we_o, .cp_re_o, .cp_reg_o, .cp_id_o, .cp_wdata_o, .cp_rdata_i,
    .pc_o, .done_o, .flag_we_o, .flag_data_o, .flag_ea_o, .illegal_o
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sext16(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  // kind: 0 bad prefix, 1 bad type, 2 set, 3 set with reserved bits, 4 short br, 5 long br
  task automatic run_instr(input int kind, input logic [15:0] op, input logic [15:0] cw,
                           input bit truth, input int retries, input logic [31:0] disp);
    int n_fetch = 0, n_we = 0, n_re = 0, n_flag = 0, n_ill = 0, left = retries;
    logic [15:0] we_data = '0;
    logic [2:0]  we_id = '0, re_id = '0;
    logic        we_reg = 1'b1, re_reg = 1'b0;
    logic [7:0]  fval = '0;
    logic [5:0]  fea = '0;
    bit          fin = 0, stalled = 0;
    logic [31:0] stall_addr = '0;
    logic [31:0] s, exp_pc;
    int exp_fetch, exp_we, exp_re, exp_flag, exp_ill;
    string rq;
    if (hung) return;
    base = pc_o;
    for (int i = 0; i < 8; i++) words[i] = 16'($urandom);
    words[0] = op;
    s = base + 32'd2 + 32'(2 * EXT);
    if (kind == 2 || kind == 3) words[1] = cw;
    if (kind == 4) words[1+EXT] = disp[15:0];
    if (kind == 5) begin words[1+EXT] = disp[31:16]; words[2+EXT] = disp[15:0]; end
    exp_we = 0; exp_re = 0; exp_flag = 0; exp_ill = 0;
    case (kind)
      0, 1: begin exp_pc = base + 32'd2; exp_fetch = 1; exp_ill = 1; rq = (kind == 0) ? "R2" : "R3"; end
      3: begin exp_pc = base + 32'd4 + 32'(2*EXT); exp_fetch = 2; exp_ill = 1; rq = "R4"; end
      2: begin exp_pc = base + 32'd4 + 32'(2*EXT); exp_fetch = 2; exp_we = 1;
               exp_re = retries + 1; exp_flag = 1; rq = "R7"; end
      4: begin exp_we = 1; exp_re = retries + 1;
               exp_pc = truth ? s + sext16(disp[15:0]) : s + 32'd2;
               exp_fetch = truth ? 2 : 1; rq = truth ? "R9" : "R8"; end
      default: begin exp_we = 1; exp_re = retries + 1;
               exp_pc = truth ? s + disp : s + 32'd4;
               exp_fetch = truth ? 3 : 1; rq = truth ? "R10" : "R8"; end
    endcase
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (stalled && fetch_req_o) chk("R11", "held fetch address", fetch_addr_o, stall_addr);
      fetch_valid_i = fetch_req_o && ($urandom % 3 != 0);
      stalled = fetch_req_o && !fetch_valid_i;
      stall_addr = fetch_addr_o;
      fetch_data_i = 16'hDEAD;
      if (fetch_valid_i) begin
        logic [31:0] off = fetch_addr_o - base;
        n_fetch++;
        if (off[31:1] < 8) fetch_data_i = words[off[3:1]];
      end
      cp_rdata_i = 16'($urandom);
      if (cp_re_o) begin
        n_re++; re_id = cp_id_o; re_reg = cp_reg_o;
        if (left > 0) begin cp_rdata_i[15] = 1'b0; left--; end
        else begin cp_rdata_i[15] = 1'b1; cp_rdata_i[0] = truth; end
      end
      if (cp_we_o) begin n_we++; we_data = cp_wdata_o; we_id = cp_id_o; we_reg = cp_reg_o; end
      @(negedge clk_i);
      if (flag_we_o) begin n_flag++; fval = flag_data_o; fea = flag_ea_o; end
      if (illegal_o) n_ill++;
      if (done_o) begin fin = 1; break; end
    end
    if (!fin) begin
      checks++; errors++; hung = 1;
      $display("FAIL %s watchdog actual=hung expected=done", rq);
      return;
    end
    chk(rq, "next pc", pc_o, exp_pc);
    chk(kind >= 4 ? "R8" : "R11", "fetch count", n_fetch, exp_fetch);
    chk("R5", "cond writes", n_we, exp_we);
    chk("R2", "illegal pulses", n_ill, exp_ill);
    chk("R7", "flag writes", n_flag, exp_flag);
    if (exp_we == 1) begin
      chk("R5", "cond word", we_data, (kind == 2) ? cw : {10'b0, op[5:0]});
      chk("R5", "cond reg select", we_reg, 1'b0);
      chk("R3", "cp id", we_id, op[11:9]);
      chk("R6", "response reads", n_re, exp_re);
      chk("R6", "resp reg select", re_reg, 1'b1);
      chk("R3", "cp id on read", re_id, op[11:9]);
    end else begin
      chk("R6", "response reads", n_re, 0);
    end
    if (exp_flag == 1) begin
      chk("R7", "flag value", fval, truth ? 8'hFF : 8'h00);
      chk("R7", "flag ea", fea, op[5:0]);
    end
  endtask

  function automatic logic [15:0] mk_op(input logic [2:0] typ);
    return {4'hF, 3'($urandom), typ, 6'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    fetch_valid_i = 1'b0; fetch_data_i = '0; cp_rdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "reset pc", pc_o, RST_PC);
    chk("R1", "reset fetch req", fetch_req_o, 1'b1);
    chk("R1", "reset fetch addr", fetch_addr_o, RST_PC);
    chk("R1", "reset pulses", {done_o, illegal_o, flag_we_o, cp_we_o}, 4'b0);

    run_instr(0, 16'h1234, '0, 0, 0, '0);
    run_instr(1, 16'hF000 | 16'h0A00, '0, 0, 0, '0);
    run_instr(1, {4'hF, 3'd5, 3'b111, 6'd9}, '0, 0, 0, '0);
    run_instr(3, mk_op(3'b001), 16'h0040 | 16'h0005, 1, 0, '0);
    run_instr(2, mk_op(3'b001), 16'h003F, 1, 0, '0);
    run_instr(2, mk_op(3'b001), 16'h0000, 0, 6, '0);
    run_instr(4, mk_op(3'b010), '0, 0, 2, 32'h0000_0100);
    run_instr(4, mk_op(3'b010), '0, 1, 0, 32'h0000_FF00);
    run_instr(4, mk_op(3'b010), '0, 1, 9, 32'h0000_7FFE);
    run_instr(5, mk_op(3'b011), '0, 1, 1, 32'hFFFF_F000);
    run_instr(5, mk_op(3'b011), '0, 0, 0, 32'h1234_5678);
    run_instr(5, mk_op(3'b011), '0, 1, 0, 32'h0001_0002);

    for (int n = 0; n < 300; n++) begin
      int k = int'($urandom % 6);
      bit t = 1'($urandom);
      int r = int'($urandom % 4);
      logic [31:0] d = $urandom;
      logic [2:0] bad_t;
      case (k)
        0: run_instr(0, {4'($urandom % 15), 12'($urandom)}, '0, t, r, d);
        1: begin
             bad_t = 3'($urandom % 5);
             if (bad_t != 0) bad_t = bad_t + 3'd3;
             run_instr(1, mk_op(bad_t), '0, t, r, d);
           end
        2: run_instr(2, mk_op(3'b001), {10'b0, 6'($urandom)}, t, r, d);
        3: run_instr(3, mk_op(3'b001), {10'(1 + $urandom % 1023), 6'($urandom)}, t, r, d);
        4: run_instr(4, mk_op(3'b010), '0, t, r, d);
        default: run_instr(5, mk_op(3'b011), '0, t, r, d);
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule